// File: doc/BRIEF.md
# Serial Dot-Matrix Command Receiver

This block takes byte-wide commands over a three-wire serial link and keeps the state that a scanner needs to drive a ten-character display. Each character is a 5x5 grid of dots. The three wires are a data line, a serial clock and an active-low load strobe. The block synchronizes those wires into its own clock domain and assembles the bits. When the strobe goes high, it carries out the byte.

Each command has a 3-bit opcode in bits 7..5 and a 5-bit payload in bits 4..0. The commands do the following:
- write one row of dots for the current character
- select a character
- clear the dot store
- set a brightness level
- start a lamp test
- enter a low-power dark state

A read port gives the scanner one full row across all characters per access. Brightness, lamp test, power-down and blank are offered to the scanner as plain levels.

Top module: `dotmx_cmd_rx`

## Requirements
- R1: While load_ni is low, each rising edge of sclk_i shifts sdat_i into an 8-bit register. The first bit sent becomes bit 0 of the byte.
- R2: A byte is carried out only on the rising edge of load_ni, with opcode = bits 7..5 and payload = bits 4..0. The control outputs do not change at any other time.
- R3: Opcodes 0..4 store the payload as row 0..4 of the current character. Payload bit 4 is column 0 and bit 0 is column 4. In rd_slice_o, character c occupies bits [5c+4:5c], and bit 5c+4 holds column 0.
- R4: Opcode 5 with a payload of 0..9 (bytes 0xB0..0xB9) selects the character that later row writes go to.
- R5: Byte 0xC0 zeroes every dot, selects character 0 and sets blank_o. Brightness level, lamp test and power-down keep their values.
- R6: Bytes 0xF0..0xF6 set bright_o to the payload's low three bits, where 0 means full and 6 means dimmest. Each of these bytes also clears lamp_test_o and pwr_down_o.
- R7: Byte 0xF8 sets lamp_test_o. While lamp test is on and power-down is off, bright_o is 1. The dot store does not change.
- R8: Byte 0xFF sets pwr_down_o, and bright_o then reads 7 (dark) regardless of lamp test. Row writes are still stored during power-down.
- R9: The following bytes change no state and no output:
  - opcode 5 with a payload above 9
  - opcode 6 with a payload other than 0
  - opcode 7 with a payload outside 0x10..0x16, 0x18 and 0x1F
- R10: blank_o is set by reset and by 0xC0. It is cleared when load_ni next falls.
- R11: While rst_ni is low, everything is cleared asynchronously: all dots are 0, character 0 is selected, bright_o is 0, lamp_test_o and pwr_down_o are 0, and blank_o is 1.
- R12: rd_slice_o shows row rd_row_i one clock after it is presented. A row index of 5 or more reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sdat_i | input | 1 | Serial data |
| sclk_i | input | 1 | Serial clock, sampled on its rising edge |
| load_ni | input | 1 | Low while shifting; rising edge executes the byte |
| rd_row_i | input | 3 | Row index for the scanner read |
| rd_slice_o | output | 50 | One row of all characters, registered |
| bright_o | output | 3 | Effective level: 0..6 dimming steps, 7 dark |
| lamp_test_o | output | 1 | Lamp test active |
| pwr_down_o | output | 1 | Power-down active |
| blank_o | output | 1 | Display blanked since reset or clear |

## Verification
Most of the state is visible only indirectly. The character address never reaches a port. A wrong address, or a bad opcode decode, shows up as dots landing in the wrong character on the next row write. That error is visible on rd_slice_o one clock after the row is read. A corrupted control register shows on bright_o, lamp_test_o or pwr_down_o within three system clocks of the strobe's rising edge. The bench therefore reads back every row after every command. It also issues row writes right after ignored address bytes, so that an address that changed when it should not have is exposed.

// File: rtl/dotmx_pkg.sv
package dotmx_pkg;
  typedef enum logic [2:0] {
    OP_ROW0 = 3'd0,
    OP_ROW1 = 3'd1,
    OP_ROW2 = 3'd2,
    OP_ROW3 = 3'd3,
    OP_ROW4 = 3'd4,
    OP_ADDR = 3'd5,
    OP_CLR  = 3'd6,
    OP_CTRL = 3'd7
  } op_e;

  localparam logic [2:0] LVL_LAMP = 3'd1;
  localparam logic [2:0] LVL_DARK = 3'd7;
  localparam logic [4:0] PAY_LAMP = 5'h18;
  localparam logic [4:0] PAY_PWR  = 5'h1F;

  typedef struct packed {
    logic [2:0] level;
    logic       lamp;
    logic       pwr;
  } ctrl_t;
endpackage

// File: rtl/dotmx_serial_front.sv
module dotmx_serial_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sdat_i,
  input  logic       sclk_i,
  input  logic       load_ni,
  output logic [7:0] byte_o,
  output logic       cmd_stb_o,
  output logic       start_o
);
  logic [SYNC_STAGES-1:0] sclk_sync, load_sync, sdat_sync;
  logic sclk_d, load_d;
  logic sclk_s, load_s, sdat_s;
  logic [7:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_sync <= '0;
      load_sync <= '1;
      sdat_sync <= '0;
      sclk_d    <= 1'b0;
      load_d    <= 1'b1;
    end else begin
      sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk_i};
      load_sync <= {load_sync[SYNC_STAGES-2:0], load_ni};
      sdat_sync <= {sdat_sync[SYNC_STAGES-2:0], sdat_i};
      sclk_d    <= sclk_s;
      load_d    <= load_s;
    end
  end

  assign sclk_s = sclk_sync[SYNC_STAGES-1];
  assign load_s = load_sync[SYNC_STAGES-1];
  assign sdat_s = sdat_sync[SYNC_STAGES-1];

  // first bit in ends up at bit 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      shift_q <= '0;
    else if (sclk_s && !sclk_d && !load_s)
      shift_q <= {sdat_s, shift_q[7:1]};
  end

  assign byte_o    = shift_q;
  assign cmd_stb_o = load_s && !load_d;
  assign start_o   = !load_s && load_d;
endmodule

// File: rtl/dotmx_cmd_decode.sv
module dotmx_cmd_decode
  import dotmx_pkg::*;
#(
  parameter int NUM_CHARS = 10,
  parameter int ADDR_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              start_i,
  input  logic [7:0]        byte_i,
  output logic [ADDR_W-1:0] addr_o,
  output ctrl_t             ctrl_o,
  output logic              blank_o,
  output logic              wr_en_o,
  output logic              clr_o
);
  localparam logic [4:0] LAST_CHAR = 5'(NUM_CHARS - 1);

  op_e        op;
  logic [4:0] pay;
  logic       lvl_cmd;

  assign op      = op_e'(byte_i[7:5]);
  assign pay     = byte_i[4:0];
  assign wr_en_o = stb_i && (op <= OP_ROW4);
  assign clr_o   = stb_i && (op == OP_CLR) && (pay == 5'd0);
  assign lvl_cmd = (pay[4:3] == 2'b10) && (pay[2:0] != 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      addr_o <= '0;
    else if (clr_o)
      addr_o <= '0;
    else if (stb_i && op == OP_ADDR && pay <= LAST_CHAR)
      addr_o <= pay[ADDR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
    end else if (stb_i && op == OP_CTRL) begin
      if (lvl_cmd) begin
        ctrl_o.level <= pay[2:0];
        ctrl_o.lamp  <= 1'b0;
        ctrl_o.pwr   <= 1'b0;
      end else if (pay == PAY_LAMP) begin
        ctrl_o.lamp <= 1'b1;
      end else if (pay == PAY_PWR) begin
        ctrl_o.pwr <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      blank_o <= 1'b1;
    else if (clr_o)
      blank_o <= 1'b1;
    else if (start_i)
      blank_o <= 1'b0;
  end
endmodule

// File: rtl/dotmx_dot_ram.sv
module dotmx_dot_ram #(
  parameter int NUM_CHARS = 10,
  parameter int NUM_ROWS  = 5,
  parameter int NUM_COLS  = 5,
  parameter int ADDR_W    = 4,
  parameter int ROW_W     = 3,
  parameter int SLICE_W   = NUM_CHARS * NUM_COLS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_char_i,
  input  logic [ROW_W-1:0]    wr_row_i,
  input  logic [NUM_COLS-1:0] wr_data_i,
  input  logic                clr_i,
  input  logic [ROW_W-1:0]    rd_row_i,
  output logic [SLICE_W-1:0]  rd_slice_o
);
  logic [SLICE_W-1:0] slice_d;
  logic               row_ok;

  assign row_ok = rd_row_i < ROW_W'(NUM_ROWS);

  for (genvar c = 0; c < NUM_CHARS; c++) begin : g_char
    logic [NUM_ROWS-1:0][NUM_COLS-1:0] rows_q;
    logic                              hit;

    assign hit = wr_en_i && (wr_char_i == ADDR_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rows_q <= '0;
      end else if (clr_i) begin
        rows_q <= '0;
      end else if (hit) begin
        for (int r = 0; r < NUM_ROWS; r++)
          if (wr_row_i == ROW_W'(r)) rows_q[r] <= wr_data_i;
      end
    end

    assign slice_d[c*NUM_COLS +: NUM_COLS] = row_ok ? rows_q[rd_row_i] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_slice_o <= '0;
    else         rd_slice_o <= slice_d;
  end
endmodule

// File: rtl/dotmx_cmd_rx.sv
module dotmx_cmd_rx
  import dotmx_pkg::*;
#(
  parameter int NUM_CHARS   = 10,
  parameter int NUM_ROWS    = 5,
  parameter int NUM_COLS    = 5,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(NUM_CHARS),
  localparam int ROW_W      = 3,
  localparam int SLICE_W    = NUM_CHARS * NUM_COLS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sdat_i,
  input  logic               sclk_i,
  input  logic               load_ni,
  input  logic [ROW_W-1:0]   rd_row_i,
  output logic [SLICE_W-1:0] rd_slice_o,
  output logic [2:0]         bright_o,
  output logic               lamp_test_o,
  output logic               pwr_down_o,
  output logic               blank_o
);
  logic [7:0]        cmd_byte;
  logic              cmd_stb, cmd_start;
  logic [ADDR_W-1:0] cur_addr;
  ctrl_t             ctrl_q;
  logic              ram_wr, ram_clr;

  dotmx_serial_front #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_front (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sdat_i   (sdat_i),
    .sclk_i   (sclk_i),
    .load_ni  (load_ni),
    .byte_o   (cmd_byte),
    .cmd_stb_o(cmd_stb),
    .start_o  (cmd_start)
  );

  dotmx_cmd_decode #(
    .NUM_CHARS(NUM_CHARS),
    .ADDR_W   (ADDR_W)
  ) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (cmd_stb),
    .start_i(cmd_start),
    .byte_i (cmd_byte),
    .addr_o (cur_addr),
    .ctrl_o (ctrl_q),
    .blank_o(blank_o),
    .wr_en_o(ram_wr),
    .clr_o  (ram_clr)
  );

  dotmx_dot_ram #(
    .NUM_CHARS(NUM_CHARS),
    .NUM_ROWS (NUM_ROWS),
    .NUM_COLS (NUM_COLS),
    .ADDR_W   (ADDR_W),
    .ROW_W    (ROW_W),
    .SLICE_W  (SLICE_W)
  ) u_ram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (ram_wr),
    .wr_char_i (cur_addr),
    .wr_row_i  (cmd_byte[7:5]),
    .wr_data_i (cmd_byte[NUM_COLS-1:0]),
    .clr_i     (ram_clr),
    .rd_row_i  (rd_row_i),
    .rd_slice_o(rd_slice_o)
  );

  // power-down outranks lamp test
  always_comb begin
    if (ctrl_q.pwr)       bright_o = LVL_DARK;
    else if (ctrl_q.lamp) bright_o = LVL_LAMP;
    else                  bright_o = ctrl_q.level;
  end

  assign lamp_test_o = ctrl_q.lamp;
  assign pwr_down_o  = ctrl_q.pwr;
endmodule

// File: rtl/dotmx_cmd_rx_chk.sv
module dotmx_cmd_rx_chk #(
  parameter int NUM_CHARS = 10,
  parameter int NUM_ROWS  = 5,
  parameter int ADDR_W    = 4,
  parameter int ROW_W     = 3,
  parameter int SLICE_W   = 50
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cmd_stb,
  input logic [7:0]         cmd_byte,
  input logic [ADDR_W-1:0]  cur_addr,
  input logic [ROW_W-1:0]   rd_row_i,
  input logic [SLICE_W-1:0] rd_slice_o,
  input logic [2:0]         bright_o,
  input logic               lamp_test_o,
  input logic               pwr_down_o,
  input logic               blank_o
);
  localparam logic [4:0] LAST_CHAR = 5'(NUM_CHARS - 1);

  assert_ctrl_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_stb |=> $stable({bright_o, lamp_test_o, pwr_down_o}));

  assert_addr_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb && cmd_byte[7:5] == 3'd5 && cmd_byte[4:0] <= LAST_CHAR
    |=> cur_addr == $past(cmd_byte[ADDR_W-1:0]));

  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb && cmd_byte == 8'hC0 |=> cur_addr == '0 && blank_o);

  assert_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb && cmd_byte[7:3] == 5'b11110 && cmd_byte[2:0] != 3'd7
    |=> !lamp_test_o && !pwr_down_o && bright_o == $past(cmd_byte[2:0]));

  assert_lamp_on_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb && cmd_byte == 8'hF8 |=> lamp_test_o);

  assert_lamp_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lamp_test_o && !pwr_down_o |-> bright_o == 3'd1);

  assert_pwr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb && cmd_byte == 8'hFF |=> pwr_down_o && bright_o == 3'd7);

  assert_bad_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb && cmd_byte[7:5] == 3'd5 && cmd_byte[4:0] > LAST_CHAR |=> $stable(cur_addr));

  assert_rd_range_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_row_i >= ROW_W'(NUM_ROWS) |=> rd_slice_o == '0);
endmodule

bind dotmx_cmd_rx dotmx_cmd_rx_chk #(
  .NUM_CHARS(NUM_CHARS),
  .NUM_ROWS (NUM_ROWS),
  .ADDR_W   (ADDR_W),
  .ROW_W    (ROW_W),
  .SLICE_W  (SLICE_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_stb    (cmd_stb),
  .cmd_byte   (cmd_byte),
  .cur_addr   (cur_addr),
  .rd_row_i   (rd_row_i),
  .rd_slice_o (rd_slice_o),
  .bright_o   (bright_o),
  .lamp_test_o(lamp_test_o),
  .pwr_down_o (pwr_down_o),
  .blank_o    (blank_o)
);

// File: tb/dotmx_cmd_rx_tb_top.sv
module dotmx_cmd_rx_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sdat_i = 1'b0;
  logic        sclk_i = 1'b1;
  logic        load_ni = 1'b1;
  logic [2:0]  rd_row_i = 3'd0;
  logic [49:0] rd_slice_o;
  logic [2:0]  bright_o;
  logic        lamp_test_o, pwr_down_o, blank_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [4:0] exp_ram [10][5];
  int         exp_addr;
  logic [2:0] exp_lvl;
  bit         exp_lamp, exp_pwr, exp_blank;

  always #5 clk_i = ~clk_i;

  dotmx_cmd_rx dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sdat_i     (sdat_i),
    .sclk_i     (sclk_i),
    .load_ni    (load_ni),
    .rd_row_i   (rd_row_i),
    .rd_slice_o (rd_slice_o),
    .bright_o   (bright_o),
    .lamp_test_o(lamp_test_o),
    .pwr_down_o (pwr_down_o),
    .blank_o    (blank_o)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_bright();
    if (exp_pwr)  return 3'd7;
    if (exp_lamp) return 3'd1;
    return exp_lvl;
  endfunction

  function automatic logic [49:0] exp_slice(int r);
    logic [49:0] s = '0;
    for (int c = 0; c < 10; c++) s[c*5 +: 5] = exp_ram[c][r];
    return s;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 10; c++)
      for (int r = 0; r < 5; r++) exp_ram[c][r] = '0;
    exp_addr = 0; exp_lvl = 3'd0; exp_lamp = 0; exp_pwr = 0; exp_blank = 1;
  endtask

  task automatic model_apply(logic [7:0] b);
    logic [2:0] op = b[7:5];
    logic [4:0] p  = b[4:0];
    if (op <= 3'd4) exp_ram[exp_addr][op] = p;
    else if (op == 3'd5) begin
      if (p <= 5'd9) exp_addr = int'(p);
    end else if (b == 8'hC0) begin
      for (int c = 0; c < 10; c++)
        for (int r = 0; r < 5; r++) exp_ram[c][r] = '0;
      exp_addr = 0; exp_blank = 1;
    end else if (op == 3'd7) begin
      if (p[4:3] == 2'b10 && p[2:0] != 3'd7) begin
        exp_lvl = p[2:0]; exp_lamp = 0; exp_pwr = 0;
      end else if (p == 5'h18) exp_lamp = 1;
      else if (p == 5'h1F) exp_pwr = 1;
    end
  endtask

  // R1: bit 0 first, data set while serial clock is low
  task automatic send_byte(logic [7:0] b);
    load_ni = 1'b0;
    exp_blank = 0;
    tick(4);
    for (int i = 0; i < 8; i++) begin
      sdat_i = b[i];
      sclk_i = 1'b0;
      tick(4);
      sclk_i = 1'b1;
      tick(4);
    end
    load_ni = 1'b1;
    tick(8);
    model_apply(b);
  endtask

  task automatic check_ctrl(string req);
    chk({req, " bright"}, 64'(bright_o), 64'(exp_bright()));
    chk({req, " lamp"},   64'(lamp_test_o), 64'(exp_lamp));
    chk({req, " pwr"},    64'(pwr_down_o), 64'(exp_pwr));
    chk({req, " blank"},  64'(blank_o), 64'(exp_blank));
  endtask

  task automatic check_ram(string req);
    for (int r = 0; r < 5; r++) begin
      rd_row_i = 3'(r);
      tick(2);
      chk({req, " row"}, 64'(rd_slice_o), 64'(exp_slice(r)));
    end
  endtask

  task automatic send_chk(logic [7:0] b, string req);
    send_byte(b);
    check_ctrl(req);
    check_ram(req);
  endtask

  function automatic logic [7:0] rand_byte();
    int k = $urandom_range(0, 9);
    case (k)
      0, 1, 2, 3, 4: return {3'($urandom_range(0, 4)), 5'($urandom_range(0, 31))};
      5: return 8'hB0 + 8'($urandom_range(0, 9));
      6: return {3'd5, 5'($urandom_range(10, 31))};
      7: return 8'hF0 + 8'($urandom_range(0, 6));
      default: begin
        case ($urandom_range(0, 6))
          0: return 8'hF8;
          1: return 8'hFF;
          2: return 8'hC0;
          3: return 8'hF7;
          4: return 8'hE5;
          5: return 8'hC3;
          default: return 8'hFB;
        endcase
      end
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    tick(3);
    // R11: reset state
    check_ctrl("R11");
    check_ram("R11");
    rst_ni = 1'b1;
    tick(2);

    // R12: rows past the last read as zero
    for (int r = 5; r < 8; r++) begin
      rd_row_i = 3'(r);
      tick(2);
      chk("R12 out of range row", 64'(rd_slice_o), 64'd0);
    end

    // R1 R3 R4 R10: select char 0, write a glyph
    send_chk(8'hB0, "R10 R4");
    send_chk(8'h1E, "R1 R3");
    send_chk(8'h31, "R3");
    send_chk(8'h51, "R3");
    send_chk(8'h71, "R3");
    send_chk(8'h9E, "R3");
    send_chk(8'hB9, "R4");
    send_chk(8'h15, "R4 last char");
    // R9: bad address keeps char 9
    send_chk(8'hBA, "R9 addr");
    send_chk(8'h2A, "R9 addr kept");
    send_chk(8'hBF, "R9 addr");
    send_chk(8'h4C, "R9 addr kept");
    // R6 levels then R5 clear keeps level
    send_chk(8'hF3, "R6");
    send_chk(8'hB4, "R4");
    send_chk(8'h07, "R3");
    send_chk(8'hC0, "R5");
    chk("R5 blank after clear", 64'(blank_o), 64'd1);
    chk("R5 level kept", 64'(bright_o), 64'd3);
    send_chk(8'h3F, "R5 R10 addr zero");
    // R9: other 110 and 111 payloads ignored
    send_chk(8'hC5, "R9 op6");
    send_chk(8'hF7, "R9 op7");
    send_chk(8'hFA, "R9 op7");
    // R7 lamp test, RAM unchanged
    send_chk(8'hF8, "R7");
    chk("R7 lamp level", 64'(bright_o), 64'd1);
    // R8 power-down over lamp, writes accepted
    send_chk(8'hFF, "R8");
    chk("R8 dark", 64'(bright_o), 64'd7);
    send_chk(8'h82, "R8 write in power-down");
    send_chk(8'hF6, "R6 resume");
    send_chk(8'hF0, "R6 full");

    // R11: reset in mid-run
    tick(1);
    rst_ni = 1'b0;
    model_reset();
    tick(2);
    check_ctrl("R11 mid");
    check_ram("R11 mid");
    rst_ni = 1'b1;
    tick(2);

    // random mix, R2 control changes only on decode
    for (int i = 0; i < 150; i++) send_chk(rand_byte(), "R2 random");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule